// File: doc/BRIEF.md
# Configurable Baseband IQ Symbol Generator

This block converts a baseband bit stream into pairs of I and Q sample words for phase-shift keyed transmission with one, two or three bits per symbol. Bits come either from a built-in pseudo-random sequence or from a serial input pin. The block groups them into symbols and adds each symbol to a programmable base index to address a small I/Q table. It then presents the selected pair on a shared sample bus to a downstream upconverter, with one write strobe for I and one for Q.

A host controls the block through a simple register write port. While the configuration input is high, the host may load the bit-rate ratio, the bits-per-symbol count, the table base index, the source select and the table contents. During this time the datapath is held idle and its outputs stay at zero. When configuration is released, the block starts counting bit periods from the first working clock edge. The parameters stay fixed until configuration is entered again. Storing different point sets in different regions of the table allows one datapath to serve every modulation.

Top module: `iqsym_gen`

## Requirements
- R1: After reset the outputs are zero with both strobes low. The register defaults are ratio 2, one bit per symbol, base index 0, internal source, and all sixteen table entries zero.
- R2: One bit period lasts `ratio` clocks, and a ratio of 0 or 1 behaves as 2. With P the effective ratio and B the effective bits per symbol, the I strobe is first high after the (P·B+1)-th rising edge seen in the working state. It is high again every P·B clocks after that.
- R3: The bits-per-symbol field takes the values 1, 2 or 3, and 0 behaves as 1. The first bit of a group becomes the most significant bit of the symbol value.
- R4: The table index is (base + symbol) modulo 16. Register map, selected by `reg_addr`: 0x00 ratio in `reg_wdata[7:0]`; 0x01 bits per symbol in `reg_wdata[1:0]`; 0x02 base in `reg_wdata[3:0]`; 0x03 source in `reg_wdata[0]` (1 = external pin); 0x10+n sets table entry n, with I in `reg_wdata[23:12]` and Q in `reg_wdata[11:0]`.
- R5: For each symbol, `tx_wr_i` is high for one clock while `tx_word` carries I. In the next clock `tx_wr_q` is high for one clock while `tx_word` carries Q. The two strobes are never high together, and `tx_word` is zero whenever neither strobe is high.
- R6: With the external source selected, `ext_bit` is sampled on the rising edge that ends each bit period. The internal source is a 15-bit shift register seeded to 0x5A3C at reset. At each bit period it forms the bit s[14] XOR s[13], uses that bit, and shifts it in at the bottom. The internal source advances at every bit period in the working state, whichever source is selected.
- R7: From the first rising edge with configuration high, the strobes and `tx_word` are zero and partial symbols are discarded. On return to the working state, timing restarts as in R2.
- R8: Register and table writes made while configuration is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | High: configuration state; low: working state |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register or table address |
| reg_wdata | input | 24 | Register write data |
| ext_bit | input | 1 | External serial bit input |
| tx_word | output | 12 | Shared I/Q sample bus to the upconverter |
| tx_wr_i | output | 1 | Write strobe for the I word |
| tx_wr_q | output | 1 | Write strobe for the Q word |

## Verification
The assertions assume that `ext_bit` is synchronous to `clk` and that the host writes registers only while `cfg_mode` is high, apart from writes that the block ignores by design. The bench meets these conditions by changing `ext_bit` and the register port only on falling clock edges. Register writes with configuration low occur only in the scenario that checks that such writes are ignored. The bench derives every expected I/Q word from its own copy of the written table, the symbol grouping rule and the shift-register sequence.

// File: rtl/iqsym_pkg.sv
// Shared widths and register addresses of the IQ symbol generator.
package iqsym_pkg;
    localparam int SAMPLE_W = 12;   // width of one I or Q word
    localparam int TBL_AW   = 4;    // table index width (16 entries)
    localparam int RATIO_W  = 8;    // bit-rate ratio register width
    localparam int MAX_BPS  = 3;    // largest group width in bits
    localparam int LFSR_W   = 15;   // internal sequence register width
    localparam logic [LFSR_W-1:0] LFSR_SEED = 15'h5A3C;

    localparam int ADDR_W   = TBL_AW + 1;
    localparam int BPS_W    = $clog2(MAX_BPS + 1);

    localparam logic [ADDR_W-1:0] A_RATIO = 5'h00;
    localparam logic [ADDR_W-1:0] A_BPS   = 5'h01;
    localparam logic [ADDR_W-1:0] A_BASE  = 5'h02;
    localparam logic [ADDR_W-1:0] A_SRC   = 5'h03;
endpackage

// File: rtl/iqsym_cfg.sv
// Parameter registers and the I/Q table.
// Writes are accepted only while cfg_mode is high; the table has a
// combinational read port indexed by the datapath.
module iqsym_cfg #(
    parameter int SW  = iqsym_pkg::SAMPLE_W,
    parameter int AW  = iqsym_pkg::TBL_AW,
    parameter int RW  = iqsym_pkg::RATIO_W,
    parameter int BW  = iqsym_pkg::BPS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_mode,
    input  logic            reg_we,
    input  logic [AW:0]     reg_addr,
    input  logic [2*SW-1:0] reg_wdata,
    input  logic [AW-1:0]   rd_idx,
    output logic [RW-1:0]   ratio,
    output logic [BW-1:0]   bps,
    output logic [AW-1:0]   base,
    output logic            ext_sel,
    output logic [2*SW-1:0] rd_entry
);
    localparam int DEPTH = 1 << AW;

    logic [2*SW-1:0] tbl [DEPTH];
    logic            wr_ok;

    assign wr_ok    = reg_we && cfg_mode;
    assign rd_entry = tbl[rd_idx];

    // Parameter register writes, configuration state only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio   <= RW'(2);
            bps     <= BW'(1);
            base    <= '0;
            ext_sel <= 1'b0;
        end else if (wr_ok && !reg_addr[AW]) begin
            case (reg_addr)
                iqsym_pkg::A_RATIO: ratio   <= reg_wdata[RW-1:0];
                iqsym_pkg::A_BPS:   bps     <= reg_wdata[BW-1:0];
                iqsym_pkg::A_BASE:  base    <= reg_wdata[AW-1:0];
                iqsym_pkg::A_SRC:   ext_sel <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Table entry writes, configuration state only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < DEPTH; n++) tbl[n] <= '0;
        end else if (wr_ok && reg_addr[AW]) begin
            tbl[reg_addr[AW-1:0]] <= reg_wdata;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_mode) |-> $stable({ratio, bps, base, ext_sel})); // R8
endmodule

// File: rtl/iqsym_bitsrc.sv
// Bit source: internal maximal-length sequence or external pin.
// Assumes ext_bit is synchronous to clk. The sequence steps on each
// bit tick, and the bit it produces is the feedback value.
module iqsym_bitsrc #(
    parameter int                LW   = iqsym_pkg::LFSR_W,
    parameter logic [LW-1:0]     SEED = iqsym_pkg::LFSR_SEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ext_sel,
    input  logic ext_bit,
    output logic bit_out
);
    logic [LW-1:0] lfsr;
    logic          fb;

    assign fb      = lfsr[LW-1] ^ lfsr[LW-2];
    assign bit_out = ext_sel ? ext_bit : fb;

    // Advance the sequence once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)    lfsr <= SEED;
        else if (tick) lfsr <= {lfsr[LW-2:0], fb};
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0); // R6
endmodule

// File: rtl/iqsym_framer.sv
// Bit-period divider and serial-to-parallel symbol grouping.
// Cleared whenever run is low. A ratio below 2 acts as 2; a group
// width of 0 acts as 1. The first bit of a group is its MSB.
module iqsym_framer #(
    parameter int RW   = iqsym_pkg::RATIO_W,
    parameter int MAXB = iqsym_pkg::MAX_BPS,
    parameter int BW   = iqsym_pkg::BPS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [RW-1:0]   ratio,
    input  logic [BW-1:0]   bps,
    input  logic            bit_in,
    output logic            tick,
    output logic            sym_done,
    output logic [MAXB-1:0] sym
);
    logic [RW-1:0]   period;
    logic [RW-1:0]   cnt;
    logic [BW-1:0]   bps_eff;
    logic [BW-1:0]   nbits;
    logic [BW-1:0]   nb_next;
    logic [MAXB-1:0] shreg;

    assign period   = (ratio < RW'(2)) ? RW'(2) : ratio;
    assign bps_eff  = (bps == '0) ? BW'(1) : bps;
    assign tick     = run && (cnt == period - RW'(1));
    assign nb_next  = nbits + BW'(1);
    assign sym      = {shreg[MAXB-2:0], bit_in};
    assign sym_done = tick && (nb_next == bps_eff);

    // Count clocks within a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + RW'(1);
    end

    // Collect bits into the current group.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            nbits <= '0;
            shreg <= '0;
        end else if (sym_done) begin
            nbits <= '0;
            shreg <= '0;
        end else if (tick) begin
            nbits <= nb_next;
            shreg <= sym;
        end
    end

    AST_BIT_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    AST_SYM_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        sym_done |-> ((sym >> bps_eff) == '0)); // R3
endmodule

// File: rtl/iqsym_gen.sv
// IQ symbol generator top. Adds the symbol to the base index, looks
// up the I/Q pair, and issues I then Q on a shared bus with one strobe
// each. Assumes register writes occur with cfg_mode high; the table is
// therefore stable while the pair is read over two cycles.
module iqsym_gen #(
    parameter int SW   = iqsym_pkg::SAMPLE_W,
    parameter int AW   = iqsym_pkg::TBL_AW,
    parameter int RW   = iqsym_pkg::RATIO_W,
    parameter int MAXB = iqsym_pkg::MAX_BPS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_mode,
    input  logic            reg_we,
    input  logic [AW:0]     reg_addr,
    input  logic [2*SW-1:0] reg_wdata,
    input  logic            ext_bit,
    output logic [SW-1:0]   tx_word,
    output logic            tx_wr_i,
    output logic            tx_wr_q
);
    localparam int BW = $clog2(MAXB + 1);

    logic            run;
    logic [RW-1:0]   ratio;
    logic [BW-1:0]   bps;
    logic [AW-1:0]   base;
    logic            ext_sel;
    logic [2*SW-1:0] entry;
    logic            tick;
    logic            src_bit;
    logic            sym_done;
    logic [MAXB-1:0] sym;
    logic [AW-1:0]   idx_q;
    logic            go_i;

    assign run = !cfg_mode;

    iqsym_cfg #(.SW(SW), .AW(AW), .RW(RW), .BW(BW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_idx(idx_q),
        .ratio(ratio), .bps(bps), .base(base), .ext_sel(ext_sel),
        .rd_entry(entry)
    );

    iqsym_bitsrc u_src (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_sel(ext_sel),
        .ext_bit(ext_bit), .bit_out(src_bit)
    );

    iqsym_framer #(.RW(RW), .MAXB(MAXB), .BW(BW)) u_frm (
        .clk(clk), .rst_n(rst_n), .run(run), .ratio(ratio), .bps(bps),
        .bit_in(src_bit), .tick(tick), .sym_done(sym_done), .sym(sym)
    );

    // Latch the table index of each finished symbol and sequence strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_mode) begin
            idx_q   <= '0;
            go_i    <= 1'b0;
            tx_wr_i <= 1'b0;
            tx_wr_q <= 1'b0;
            tx_word <= '0;
        end else begin
            if (sym_done) idx_q <= base + AW'(sym);
            go_i    <= sym_done;
            tx_wr_i <= go_i;
            tx_wr_q <= tx_wr_i;
            if (go_i)         tx_word <= entry[2*SW-1:SW];
            else if (tx_wr_i) tx_word <= entry[SW-1:0];
            else              tx_word <= '0;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_wr_i && tx_wr_q)); // R5
    AST_Q_FOLLOWS_I: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_i && !cfg_mode) |=> tx_wr_q); // R5
    AST_Q_NEEDS_I: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_q |-> $past(tx_wr_i)); // R5
    AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_wr_i && !tx_wr_q) |-> (tx_word == '0)); // R5
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_mode) |-> (!tx_wr_i && !tx_wr_q && tx_word == '0)); // R7
endmodule

// File: tb/iqsym_gen_tb.sv
module iqsym_gen_tb;
    localparam logic [14:0] SEED = 15'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_mode;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [23:0] reg_wdata;
    logic        ext_bit;
    logic [11:0] tx_word;
    logic        tx_wr_i;
    logic        tx_wr_q;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc   = 0;
    logic [23:0] model [16];
    int          sc;
    int          sp;
    logic [31:0] sdrive;

    always #4 clk = ~clk;

    iqsym_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ext_bit(ext_bit),
        .tx_word(tx_word), .tx_wr_i(tx_wr_i), .tx_wr_q(tx_wr_q)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        cfg_mode = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        ext_bit = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 16; n++) model[n] = '0;
    endtask

    task automatic wr(logic [4:0] a, logic [23:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load_table(int off);
        for (int n = 0; n < 16; n++) begin
            logic [11:0] iv;
            logic [11:0] qv;
            iv = 12'(n * 211 + off + 1);
            qv = 12'(n * 97 + 3 * off + 5);
            model[n] = {iv, qv};
            wr(5'h10 + 5'(n), {iv, qv});
        end
    endtask

    task automatic setup(int ratio, int bps, int base, int src);
        wr(5'h00, 24'(ratio));
        wr(5'h01, 24'(bps));
        wr(5'h02, 24'(base));
        wr(5'h03, 24'(src));
    endtask

    // One falling-edge step; drives the next external bit at bit boundaries.
    task automatic step();
        @(negedge clk);
        sc++;
        if ((sc % sp) == 0 && (sc / sp) < 32) ext_bit = sdrive[sc / sp];
    endtask

    // Enter working state, check nsym symbols, return to configuration.
    task automatic run_sym(int p, int b, int base, logic [31:0] drive,
                           logic [31:0] expb, int nsym, string tag);
        @(negedge clk);
        sc = 0; sp = p; sdrive = drive;
        ext_bit = drive[0];
        cfg_mode = 1'b0;
        for (int k = 0; k < nsym; k++) begin
            int sym;
            int idx;
            int exp_at;
            sym = 0;
            for (int t = 0; t < b; t++) sym = sym * 2 + int'(expb[k * b + t]);
            idx = (base + sym) % 16;
            exp_at = (k + 1) * p * b + 1;
            while (!tx_wr_i && sc < exp_at + 4) step();
            chk({tag, " R2 I strobe cycle"}, sc, exp_at);
            chk({tag, " R4 I word"}, int'(tx_word), int'(model[idx][23:12]));
            step();
            chk({tag, " R5 Q strobe"}, int'(tx_wr_q), 1);
            chk({tag, " R5 I low with Q"}, int'(tx_wr_i), 0);
            chk({tag, " R4 Q word"}, int'(tx_word), int'(model[idx][11:0]));
        end
        cfg_mode = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 reset word", int'(tx_word), 0);
        chk("R1 reset strobes", int'({tx_wr_i, tx_wr_q}), 0);
    endtask

    task automatic t_defaults();
        do_reset();
        run_sym(2, 1, 0, 32'hFFFF_FFFF, 32'h0, 3, "defaults R1");
    endtask

    task automatic t_bpsk();
        do_reset();
        load_table(7);
        setup(5, 1, 0, 1);
        run_sym(5, 1, 0, 32'b1101, 32'b1101, 4, "bpsk R3 R6");
    endtask

    task automatic t_qpsk();
        do_reset();
        load_table(40);
        setup(3, 2, 4, 1);
        run_sym(3, 2, 4, 32'b10_11_01_00, 32'b10_11_01_00, 4, "qpsk R3");
    endtask

    task automatic t_8psk();
        do_reset();
        load_table(90);
        setup(2, 3, 8, 1);
        run_sym(2, 3, 8, 32'b011_110_101, 32'b011_110_101, 3, "8psk R3");
    endtask

    task automatic t_wrap();
        do_reset();
        load_table(3);
        setup(1, 0, 15, 1);
        run_sym(2, 1, 15, 32'b0110, 32'b0110, 4, "wrap R2 R3 R4");
    endtask

    task automatic t_internal();
        logic [14:0] s;
        logic [31:0] eb;
        do_reset();
        s = SEED;
        for (int j = 0; j < 32; j++) begin
            logic fb;
            fb = s[14] ^ s[13];
            eb[j] = fb;
            s = {s[13:0], fb};
        end
        load_table(17);
        setup(4, 2, 0, 0);
        run_sym(4, 2, 0, ~eb, eb, 5, "internal R6");
    endtask

    task automatic t_cfg_quiet();
        do_reset();
        load_table(55);
        setup(4, 2, 4, 1);
        @(negedge clk);
        sc = 0; sp = 4; sdrive = 32'b0110;
        ext_bit = sdrive[0];
        cfg_mode = 1'b0;
        while (!tx_wr_i && sc < 20) step();
        chk("R7 strobe seen before abort", int'(tx_wr_i), 1);
        cfg_mode = 1'b1;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            chk("R7 quiet in configuration",
                int'({tx_word, tx_wr_i, tx_wr_q}), 0);
        end
        run_sym(4, 2, 4, 32'b0011, 32'b0011, 2, "restart R7");
    endtask

    task automatic t_frozen();
        do_reset();
        load_table(21);
        setup(3, 1, 0, 1);
        @(negedge clk);
        cfg_mode = 1'b0;
        wr(5'h10, 24'hABC_DEF);
        wr(5'h11, 24'h123_456);
        wr(5'h02, 24'd5);
        wr(5'h00, 24'd7);
        wr(5'h01, 24'd3);
        @(negedge clk);
        cfg_mode = 1'b1;
        run_sym(3, 1, 0, 32'b0110, 32'b0110, 4, "frozen R8");
    endtask

    initial begin
        rst_n = 1'b0; cfg_mode = 1'b1; reg_we = 1'b0;
        reg_addr = '0; reg_wdata = '0; ext_bit = 1'b0;
        t_reset();
        t_defaults();
        t_bpsk();
        t_qpsk();
        t_8psk();
        t_wrap();
        t_internal();
        t_cfg_quiet();
        t_frozen();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule